// File: doc/BRIEF.md
# Timer-Counter with Steerable Prescaler

This block is an 8-bit timer/counter that software can load and read at any time. It counts one of two things. The first is instruction-cycle strobes from the core, which arrive as the `cyc_en` input. The second is edges on an external pin. The pin is first passed through a two-stage synchronizer and an edge detector, and a mode bit selects whether rising or falling edges count. When the count rolls over from FFh to 00h, it sets a sticky overflow flag. Only an explicit clear removes that flag. A separate enable decides whether the flag drives the interrupt output.

An 8-bit divide-by-2^n prescaler sits between the count source and the counter. It can be handed instead to a watchdog path, where it divides a watchdog oscillator strobe (`wd_src`) into `wd_tick`. Whichever of the two paths does not own the prescaler runs undivided. The prescaler state is not visible at any port. A one-hot tap chosen by the 3-bit rate field sets the divide ratio.

A small state machine suppresses counting after every count write. It has three states: RUN, SKIP2 and SKIP1. A count write moves it from any state to SKIP2. An instruction-cycle strobe moves it from SKIP2 to SKIP1, and the next strobe moves it from SKIP1 to RUN. The counter may only advance in RUN.

Top module: `shared_div_timer`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, `irq` is 0 and the option register reads 6'h3F.
- R2: `cnt_wr` loads `wr_data` into the count and `opt_wr` loads `wr_data[5:0]` into the options. Both registers read back on `cnt_q` and `opt_q`. The option bits are: bit 5 source (0 = instruction cycles, 1 = external pin), bit 4 edge (0 = rising, 1 = falling), bit 3 prescaler owner (1 = watchdog, 0 = timer), and bits 2:0 the rate.
- R3: With source 0 and the prescaler on the watchdog, the count rises by one for each clock edge that has `cyc_en` high. It wraps from FFh to 00h. `ext_pin` has no effect on the count in this mode.
- R4: After a count write, the next two clock edges that have `cyc_en` high do not advance the count. This holds in both source modes. The write cycle itself loads the count and does not increment it.
- R5: With the prescaler on the timer, the count advances once per 2^(rate+1) source ticks. A count write in this setting also clears the prescaler, so the Nth source tick after the write produces an increment when N is a multiple of the ratio, unless R4 suppresses it.
- R6: With source 1, the count advances on rising pin edges when the edge bit is 0 and on falling pin edges when it is 1. `cyc_en` does not advance the count in this mode.
- R7: A pin change that sets up before clock edge A shows in the count after the third clock edge counting A, and not after the first or second.
- R8: An increment from FFh sets the overflow flag. The flag stays set until `flag_clr` is high at a clock edge. When a wrap and `flag_clr` happen in the same cycle, the wrap wins.
- R9: `irq` is high exactly when the overflow flag is set and `irq_en` is high.
- R10: With the prescaler on the watchdog, `wd_tick` gives one pulse per 2^rate `wd_src` strobes. With the prescaler on the timer, `wd_tick` follows `wd_src` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle strobe |
| cnt_wr | input | 1 | Load the count from `wr_data` |
| opt_wr | input | 1 | Load the options from `wr_data[5:0]` |
| wr_data | input | 8 | Write data |
| cnt_q | output | 8 | Count readback |
| opt_q | output | 6 | Option readback |
| ext_pin | input | 1 | External count input, asynchronous |
| wd_src | input | 1 | Watchdog oscillator strobe |
| wd_tick | output | 1 | Watchdog tick, divided or direct |
| flag_clr | input | 1 | Clear the overflow flag |
| irq_en | input | 1 | Interrupt mask enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench sweeps every rate code on both prescaler owners and computes each expected count or pulse total from the ratio. With the wrong tap, or a prescaler that is not cleared on a write, the count would be off by whole ratio steps. With the wrong watchdog offset, every sweep would show twice or half the expected pulses. A sweep of the number of strobes after a write catches an inhibit window that is one cycle too long or too short. A pin test checks both polarities and samples the cycles right after the pin change, which exposes a synchronizer with the wrong depth or an inverted edge select. The overflow tests check that the flag survives further counting, that a clear issued together with a wrap loses, and that `irq_en` gates the output.

// File: rtl/sdt_pkg.sv
`timescale 1ns/1ps
package sdt_pkg;
    localparam int PRE_W  = 8;
    localparam int RATE_W = $clog2(PRE_W);

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SKIP2 = 2'd1,
        ST_SKIP1 = 2'd2
    } hold_st_t;

    typedef struct packed {
        logic              src_ext;
        logic              edge_fall;
        logic              pre_to_wd;
        logic [RATE_W-1:0] rate;
    } opt_t;

    localparam int OPT_W = $bits(opt_t);
endpackage

// File: rtl/sdt_edge_sync.sv
`timescale 1ns/1ps
module sdt_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic evt_o
);
    logic [SYNC_STAGES-1:0] sh;
    logic                   prev;
    logic                   s;

    assign s = sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[SYNC_STAGES-2:0], pin_i};
            prev <= s;
        end
    end

    always_comb begin
        if (fall_sel_i) evt_o = prev & ~s;
        else            evt_o = s & ~prev;
    end

    // R7
    sync_rise_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !fall_sel_i) |-> $past(pin_i, SYNC_STAGES));
endmodule

// File: rtl/sdt_prescaler.sv
`timescale 1ns/1ps
module sdt_prescaler import sdt_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              to_wd_i,
    output logic              out_o
);
    logic [PRE_W-1:0]  pre;
    logic [RATE_W:0]   wsel;
    logic [PRE_W-1:0]  need_m;

    always_comb begin
        wsel   = to_wd_i ? {1'b0, rate_i} : ({1'b0, rate_i} + 1'b1);
        need_m = ~({PRE_W{1'b1}} << wsel);
        out_o  = tick_i & ((pre & need_m) == need_m);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      pre <= '0;
        else if (clr_i)  pre <= '0;
        else if (tick_i) pre <= pre + 1'b1;
    end

    // R5
    first_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_wd_i && $past(clr_i)) |-> !out_o);
endmodule

// File: rtl/sdt_wr_hold.sv
`timescale 1ns/1ps
module sdt_wr_hold import sdt_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic cyc_i,
    output logic block_o
);
    hold_st_t st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_RUN:   st_nx = ST_RUN;
            ST_SKIP2: if (cyc_i) st_nx = ST_SKIP1;
            ST_SKIP1: if (cyc_i) st_nx = ST_RUN;
            default:  st_nx = ST_RUN;
        endcase
        if (wr_i) st_nx = ST_SKIP2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        block_o = (st != ST_RUN);
    end

    // R4
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> block_o);
    // R4
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP1 && cyc_i && !wr_i) |=> !block_o);
endmodule

// File: rtl/shared_div_timer.sv
`timescale 1ns/1ps
module shared_div_timer import sdt_pkg::*; #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             cnt_wr,
    input  logic             opt_wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic [OPT_W-1:0] opt_q,
    input  logic             ext_pin,
    input  logic             wd_src,
    output logic             wd_tick,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic             ovf_flag,
    output logic             irq
);
    opt_t             opt_r;
    logic [CNT_W-1:0] cnt_r;
    logic             flag_r;
    logic             ext_evt, src_tick, pre_in, pre_out, pre_clr;
    logic             tmr_tick, blk, tmr_inc, wrap;

    sdt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_pin),
        .fall_sel_i (opt_r.edge_fall),
        .evt_o      (ext_evt)
    );

    always_comb begin
        src_tick = opt_r.src_ext ? ext_evt : cyc_en;
        pre_in   = opt_r.pre_to_wd ? wd_src : src_tick;
        pre_clr  = cnt_wr & ~opt_r.pre_to_wd;
    end

    sdt_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (pre_clr),
        .tick_i  (pre_in),
        .rate_i  (opt_r.rate),
        .to_wd_i (opt_r.pre_to_wd),
        .out_o   (pre_out)
    );

    sdt_wr_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cnt_wr),
        .cyc_i   (cyc_en),
        .block_o (blk)
    );

    always_comb begin
        tmr_tick = opt_r.pre_to_wd ? src_tick : pre_out;
        wd_tick  = opt_r.pre_to_wd ? pre_out : wd_src;
        tmr_inc  = tmr_tick & ~blk;
        wrap     = tmr_inc & (&cnt_r) & ~cnt_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r  <= '0;
            opt_r  <= opt_t'({OPT_W{1'b1}});
            flag_r <= 1'b0;
        end else begin
            if (cnt_wr)       cnt_r <= wr_data;
            else if (tmr_inc) cnt_r <= cnt_r + 1'b1;
            if (opt_wr)       opt_r <= opt_t'(wr_data[OPT_W-1:0]);
            if (wrap)          flag_r <= 1'b1;
            else if (flag_clr) flag_r <= 1'b0;
        end
    end

    always_comb begin
        cnt_q    = cnt_r;
        opt_q    = opt_r;
        ovf_flag = flag_r;
        irq      = flag_r & irq_en;
    end

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);
    // R8
    wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_inc && (&cnt_q) && !cnt_wr) |=> (cnt_q == '0 && ovf_flag));
    // R4
    blocked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && !cnt_wr) |=> $stable(cnt_q));
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

// File: tb/sim_shared_div_timer.sv
`timescale 1ns/1ps
module sim_shared_div_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0, cnt_wr = 1'b0, opt_wr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] cnt_q;
    logic [5:0] opt_q;
    logic       ext_pin = 1'b0, wd_src = 1'b0, wd_tick;
    logic       flag_clr = 1'b0, irq_en = 1'b0, ovf_flag, irq;
    int         vec = 0, bad = 0;

    always #2.5 clk = ~clk;

    shared_div_timer u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cnt_wr(cnt_wr),
        .opt_wr(opt_wr), .wr_data(wr_data), .cnt_q(cnt_q), .opt_q(opt_q),
        .ext_pin(ext_pin), .wd_src(wd_src), .wd_tick(wd_tick),
        .flag_clr(flag_clr), .irq_en(irq_en), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_wr = 1'b1; wr_data = v;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic wr_opt(input logic [5:0] v);
        opt_wr = 1'b1; wr_data = {2'b00, v};
        @(negedge clk);
        opt_wr = 1'b0;
    endtask

    task automatic cyc(input int n);
        cyc_en = 1'b1;
        repeat (n) @(negedge clk);
        cyc_en = 1'b0;
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", cnt_q, 0);
        chk("R1 flag", ovf_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 opt", opt_q, 6'h3F);

        // R2 readback
        wr_opt(6'b001000);
        chk("R2 opt", opt_q, 6'b001000);
        wr_cnt(8'hA5);
        chk("R2 count", cnt_q, 8'hA5);

        // R3 R4 strobe sweep after a write
        for (int n = 0; n <= 6; n++) begin
            wr_cnt(8'd5);
            cyc(n);
            chk($sformatf("R4 n=%0d", n), cnt_q, 5 + ((n > 2) ? n - 2 : 0));
        end

        // R3 pin ignored in timer mode
        wr_cnt(8'd9);
        for (int i = 0; i < 6; i++) begin
            ext_pin = ~ext_pin;
            repeat (3) @(negedge clk);
        end
        ext_pin = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 pin ignored", cnt_q, 9);

        // R5 prescaled timer sweep
        for (int r = 0; r < 8; r++) begin
            int ratio, m, e;
            ratio = 2 << r;
            m = 3 * ratio + 1;
            e = 0;
            for (int k = 3; k <= m; k++) if (k % ratio == 0) e++;
            wr_opt({3'b000, 3'(r)});
            wr_cnt(8'd0);
            cyc(m);
            chk($sformatf("R5 rate=%0d", r), cnt_q, e);
        end

        // R7 synchronizer latency, rising edge
        wr_opt(6'b101000);
        wr_cnt(8'd0);
        cyc_en = 1'b1;
        repeat (3) @(negedge clk);
        ext_pin = 1'b1;
        @(negedge clk);
        chk("R7 edge+1", cnt_q, 0);
        @(negedge clk);
        chk("R7 edge+2", cnt_q, 0);
        @(negedge clk);
        chk("R7 edge+3", cnt_q, 1);
        repeat (3) @(negedge clk);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        cyc_en = 1'b0;

        // R6 both polarities, cyc_en held high
        for (int e = 0; e < 2; e++) begin
            wr_opt({1'b1, 1'(e), 1'b1, 3'b000});
            wr_cnt(8'd0);
            cyc_en = 1'b1;
            repeat (3) @(negedge clk);
            for (int p = 1; p <= 5; p++) begin
                ext_pin = 1'b1;
                repeat (4) @(negedge clk);
                ext_pin = 1'b0;
                repeat (4) @(negedge clk);
                chk($sformatf("R6 edge=%0d p=%0d", e, p), cnt_q, p);
            end
            ext_pin = 1'b1;
            repeat (4) @(negedge clk);
            chk($sformatf("R6 half edge=%0d", e), cnt_q, (e == 1) ? 5 : 6);
            ext_pin = 1'b0;
            repeat (4) @(negedge clk);
            chk($sformatf("R6 end edge=%0d", e), cnt_q, 6);
            cyc_en = 1'b0;
        end

        // R8 R9 overflow and masking
        wr_opt(6'b001000);
        wr_cnt(8'hFE);
        cyc(4);
        chk("R8 wrap count", cnt_q, 0);
        chk("R8 flag set", ovf_flag, 1);
        chk("R9 masked", irq, 0);
        irq_en = 1'b1;
        #1;
        chk("R9 unmasked", irq, 1);
        @(negedge clk);
        cyc(3);
        chk("R8 sticky", ovf_flag, 1);
        wr_cnt(8'hFF);
        cyc(2);
        chk("R8 held FF", cnt_q, 8'hFF);
        cyc_en = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        cyc_en = 1'b0; flag_clr = 1'b0;
        chk("R8 set wins count", cnt_q, 0);
        chk("R8 set wins flag", ovf_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R8 cleared", ovf_flag, 0);
        chk("R9 irq low", irq, 0);
        irq_en = 1'b0;

        // R10 watchdog division sweep
        for (int r = 0; r < 8; r++) begin
            int n;
            n = 0;
            wr_opt({3'b001, 3'(r)});
            wd_src = 1'b1;
            for (int i = 0; i < (4 << r); i++) begin
                #1;
                if (wd_tick) n++;
                @(negedge clk);
            end
            wd_src = 1'b0;
            chk($sformatf("R10 rate=%0d", r), n, 4);
        end

        // R10 direct path
        wr_opt(6'b000011);
        for (int i = 0; i < 8; i++) begin
            wd_src = i[0];
            #1;
            chk($sformatf("R10 direct i=%0d", i), wd_tick, i[0]);
            @(negedge clk);
        end
        wd_src = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule